// File: doc/BRIEF.md
# Bus-Master DMA Channel Register and Control Unit

This block holds the programming state of one bus-master DMA channel that serves a SCSI protocol core. Software sees eight 32-bit registers through a simple indexed read/write port: a command register, three shadow start registers (count, physical address, descriptor-list address), three working registers that track the transfer in progress, and a status register. A second port carries a separate bus-and-control word, and one bit of that word selects how the error, abort and done status flags are cleared.

Writing the command register decodes its two-bit operation field. A start reloads the working registers from the shadow start registers, wipes the status flags and enables the core. An idle disables the core. An abort sends a one-cycle cancel pulse to the core. A blast only stores the value. While the channel runs, the core presents transfer requests with a direction and a length. The block clamps each request to the bytes left, checks the direction against the command register, and updates the working count and address. A completion pulse from the core zeroes the working count and raises the done flag, which can drive an interrupt.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the command, start count, start address, start descriptor and working count registers read 0. The working address reads 0xFFFFFFFF and the working descriptor reads 0xFFFFFFFD. Status and the control word read 0, and core_en, core_cancel and irq are 0.
- R2: The register index selects 0 = command, 1 = start count, 2 = start address, 3 = start descriptor, 4 = working count, 5 = working address, 6 = working descriptor, 7 = status. Indices 0 to 6 read back the last value written. Read data appears in the cycle after reg_rd.
- R3: A command write whose bits [1:0] are 3 (start) copies start count, start address and start descriptor into the working count, working address and working descriptor. It clears status bits 0 to 5 and sets core_en.
- R4: A command write with bits [1:0] = 0 (idle) clears core_en. Bits [1:0] = 1 (blast) only stores the value and leaves core_en and the other registers as they were.
- R5: A command write with bits [1:0] = 2 (abort) pulses core_cancel high for the following cycle and sets status bit 2.
- R6: A transfer request whose direction matches command bit 7 (1 = device to memory) is granted. Its length is the smaller of the requested length and the working count. The working count drops by that length and the working address rises by it. If the working count becomes 0, status bit 5 is set. xfer_ack, xfer_grant and xfer_len_out appear one cycle after the request.
- R7: A request whose direction differs from command bit 7 is refused with xfer_grant = 0 and xfer_len_out = 0. It leaves the working count and working address unchanged and sets status bit 1.
- R8: A completion pulse forces the working count to 0 and sets status bit 3.
- R9: With control bit 12 = 0, writing ones to status bits 1, 2 and 3 clears those bits. A status read leaves them in place.
- R10: With control bit 12 = 1, a status read returns the current value and then clears bits 1, 2 and 3. Writes to the status register have no effect.
- R11: A status read returns bit 4 as 1 whenever core_irq is high.
- R12: irq is high exactly when status bit 3 and command bit 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | DATA_W | Control word write data |
| ctl_rdata | output | DATA_W | Current control word |
| xfer_req | input | 1 | Core transfer request |
| xfer_dir | input | 1 | Request direction, 1 = device to memory |
| xfer_len | input | LEN_W | Requested length in bytes |
| xfer_ack | output | 1 | Request answered, one cycle later |
| xfer_grant | output | 1 | Request accepted |
| xfer_len_out | output | LEN_W | Clamped length moved |
| core_done | input | 1 | Core command-completion pulse |
| core_irq | input | 1 | Core interrupt pending level |
| core_en | output | 1 | DMA enable toward the core |
| core_cancel | output | 1 | One-cycle cancel pulse toward the core |
| irq | output | 1 | Done interrupt |

## Verification
The assertions watch, on every cycle, the handshake-level rules: the enable after start and idle commands, the cancel pulse appearing only after an abort, the answer to each transfer request, the clamped length never exceeding the request, a refused request carrying zero length, and a completion zeroing the count and raising the interrupt when enabled. The values that depend on history can only be shown by the bench's scenarios, which compare readback against a reference model. These are the reload from the shadow registers, the running count and address, the status flags under both clearing modes, and the injected core interrupt bit.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_CMD  = 3'd0,
    IDX_SCNT = 3'd1,
    IDX_SADR = 3'd2,
    IDX_SDSC = 3'd3,
    IDX_WCNT = 3'd4,
    IDX_WADR = 3'd5,
    IDX_WDSC = 3'd6,
    IDX_STAT = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } chan_op_e;

  localparam int CMD_DIR_BIT     = 7;
  localparam int CMD_DONE_IE_BIT = 6;

  localparam int ST_W    = 6;
  localparam int ST_PWDN = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_ABT  = 2;
  localparam int ST_DONE = 3;
  localparam int ST_SCSI = 4;
  localparam int ST_BCZ  = 5;

  // flags that the selectable clear mechanism acts on
  localparam logic [ST_W-1:0] ST_CLR_MASK = 6'b001110;

  typedef struct packed {
    logic go_idle;
    logic go_abort;
    logic go_start;
  } cmd_act_t;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       op_field,
  output cmd_act_t         act
);

  logic cmd_hit;

  assign cmd_hit = wr_en && (reg_idx_e'(idx) == IDX_CMD);

  always_comb begin
    act = '0;
    if (cmd_hit) begin
      case (chan_op_e'(op_field))
        OP_IDLE:  act.go_idle  = 1'b1;
        OP_ABORT: act.go_abort = 1'b1;
        OP_START: act.go_start = 1'b1;
        default:  act = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_xfer_clamp.sv
module dma_xfer_clamp #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              req,
  input  logic              req_dir,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cmd_dir,
  input  logic [DATA_W-1:0] wcnt,
  output logic              accept,
  output logic              reject,
  output logic [LEN_W-1:0]  take,
  output logic              drains
);

  logic [DATA_W-1:0] len_ext;

  assign len_ext = DATA_W'(req_len);
  assign accept  = req && (req_dir == cmd_dir);
  assign reject  = req && (req_dir != cmd_dir);
  assign take    = (wcnt < len_ext) ? wcnt[LEN_W-1:0] : req_len;
  assign drains  = accept && (DATA_W'(take) == wcnt);

endmodule

// File: rtl/dma_stat_unit.sv
module dma_stat_unit
  import dma_chan_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all,
  input  logic            w1c_en,
  input  logic [ST_W-1:0] w1c_mask,
  input  logic            cor_en,
  input  logic [ST_W-1:0] set_mask,
  output logic [ST_W-1:0] stat_q
);

  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    logic kill;
    if (ST_CLR_MASK[b]) begin : g_clr
      assign kill = clr_all || (w1c_en && w1c_mask[b]) || cor_en;
    end else begin : g_keep
      assign kill = clr_all;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q[b] <= 1'b0;
      end else begin
        stat_q[b] <= (stat_q[b] && !kill) || set_mask[b];
      end
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 16,
  parameter int MODE_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              xfer_req,
  input  logic              xfer_dir,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_ack,
  output logic              xfer_grant,
  output logic [LEN_W-1:0]  xfer_len_out,
  input  logic              core_done,
  input  logic              core_irq,
  output logic              core_en,
  output logic              core_cancel,
  output logic              irq
);

  localparam logic [DATA_W-1:0] WADR_RST = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] WDSC_RST = {{(DATA_W-2){1'b1}}, 2'b01};

  logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdsc_q;
  logic [DATA_W-1:0] wcnt_q, wadr_q, wdsc_q, ctl_q;
  logic [ST_W-1:0]   stat_q, set_mask;
  logic [DATA_W-1:0] rd_mux;
  cmd_act_t          act;
  logic              accept, reject, drains;
  logic [LEN_W-1:0]  take;
  logic              wr_hit_stat, rd_hit_stat, cor_mode;

  dma_cmd_decode u_dec (
    .wr_en    (reg_wr),
    .idx      (reg_idx),
    .op_field (reg_wdata[1:0]),
    .act      (act)
  );

  dma_xfer_clamp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_clamp (
    .req     (xfer_req),
    .req_dir (xfer_dir),
    .req_len (xfer_len),
    .cmd_dir (cmd_q[CMD_DIR_BIT]),
    .wcnt    (wcnt_q),
    .accept  (accept),
    .reject  (reject),
    .take    (take),
    .drains  (drains)
  );

  assign cor_mode    = ctl_q[MODE_BIT];
  assign wr_hit_stat = reg_wr && (reg_idx_e'(reg_idx) == IDX_STAT);
  assign rd_hit_stat = reg_rd && (reg_idx_e'(reg_idx) == IDX_STAT);

  always_comb begin
    set_mask          = '0;
    set_mask[ST_ERR]  = reject;
    set_mask[ST_ABT]  = act.go_abort;
    set_mask[ST_DONE] = core_done;
    set_mask[ST_BCZ]  = drains && !core_done;
  end

  dma_stat_unit u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (act.go_start),
    .w1c_en   (wr_hit_stat && !cor_mode),
    .w1c_mask (reg_wdata[ST_W-1:0]),
    .cor_en   (rd_hit_stat && cor_mode),
    .set_mask (set_mask),
    .stat_q   (stat_q)
  );

  // shadow registers and command
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      scnt_q <= '0;
      sadr_q <= '0;
      sdsc_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_idx_e'(reg_idx))
          IDX_CMD:  cmd_q  <= reg_wdata;
          IDX_SCNT: scnt_q <= reg_wdata;
          IDX_SADR: sadr_q <= reg_wdata;
          IDX_SDSC: sdsc_q <= reg_wdata;
          default: ;
        endcase
      end
      if (ctl_wr) ctl_q <= ctl_wdata;
    end
  end

  // working registers: register write, then start reload, then completion, then transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q <= '0;
      wadr_q <= WADR_RST;
      wdsc_q <= WDSC_RST;
    end else begin
      if (reg_wr && reg_idx_e'(reg_idx) == IDX_WCNT) wcnt_q <= reg_wdata;
      else if (act.go_start)                         wcnt_q <= scnt_q;
      else if (core_done)                            wcnt_q <= '0;
      else if (accept)                               wcnt_q <= wcnt_q - DATA_W'(take);

      if (reg_wr && reg_idx_e'(reg_idx) == IDX_WADR) wadr_q <= reg_wdata;
      else if (act.go_start)                         wadr_q <= sadr_q;
      else if (accept)                               wadr_q <= wadr_q + DATA_W'(take);

      if (reg_wr && reg_idx_e'(reg_idx) == IDX_WDSC) wdsc_q <= reg_wdata;
      else if (act.go_start)                         wdsc_q <= sdsc_q;
    end
  end

  always_comb begin
    case (reg_idx_e'(reg_idx))
      IDX_CMD:  rd_mux = cmd_q;
      IDX_SCNT: rd_mux = scnt_q;
      IDX_SADR: rd_mux = sadr_q;
      IDX_SDSC: rd_mux = sdsc_q;
      IDX_WCNT: rd_mux = wcnt_q;
      IDX_WADR: rd_mux = wadr_q;
      IDX_WDSC: rd_mux = wdsc_q;
      default: begin
        rd_mux = DATA_W'(stat_q);
        rd_mux[ST_SCSI] = stat_q[ST_SCSI] | core_irq;
      end
    endcase
  end

  // registered outputs toward software and the core
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      core_en      <= 1'b0;
      core_cancel  <= 1'b0;
      xfer_ack     <= 1'b0;
      xfer_grant   <= 1'b0;
      xfer_len_out <= '0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      if (act.go_start)     core_en <= 1'b1;
      else if (act.go_idle) core_en <= 1'b0;
      core_cancel  <= act.go_abort;
      xfer_ack     <= xfer_req;
      xfer_grant   <= accept;
      xfer_len_out <= accept ? take : '0;
    end
  end

  assign ctl_rdata = ctl_q;
  assign irq       = stat_q[ST_DONE] & cmd_q[CMD_DONE_IE_BIT];

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_idx,
  input logic [1:0]        wr_op,
  input logic              xfer_req,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_ack,
  input logic              xfer_grant,
  input logic [LEN_W-1:0]  xfer_len_out,
  input logic              core_done,
  input logic              core_en,
  input logic              core_cancel,
  input logic              irq,
  input logic              cmd_ie,
  input logic [DATA_W-1:0] wcnt_q
);

  logic cmd_wr;
  assign cmd_wr = reg_wr && (reg_idx == 3'd0);

  AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wr_op == 2'd3) |=> core_en);  // R3

  AST_IDLE_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wr_op == 2'd0) |=> !core_en);  // R4

  AST_CANCEL_ONLY_ON_ABORT: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && wr_op == 2'd2) |=> !core_cancel);  // R5

  AST_ABORT_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wr_op == 2'd2) |=> core_cancel);  // R5

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> xfer_ack);  // R6

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> (xfer_len_out <= $past(xfer_len)));  // R6

  AST_REFUSED_NO_LEN: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack && !xfer_grant) |-> (xfer_len_out == '0));  // R7

  AST_DONE_ZEROES_COUNT: assert property (@(posedge clk) disable iff (rst)
    (core_done && !reg_wr) |=> (wcnt_q == '0));  // R8

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (core_done && !reg_wr && cmd_ie) |=> irq);  // R12

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr       (reg_wr),
  .reg_idx      (reg_idx),
  .wr_op        (reg_wdata[1:0]),
  .xfer_req     (xfer_req),
  .xfer_len     (xfer_len),
  .xfer_ack     (xfer_ack),
  .xfer_grant   (xfer_grant),
  .xfer_len_out (xfer_len_out),
  .core_done    (core_done),
  .core_en      (core_en),
  .core_cancel  (core_cancel),
  .irq          (irq),
  .cmd_ie       (cmd_q[6]),
  .wcnt_q       (wcnt_q)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;

  localparam int DW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic ctl_wr = 1'b0;
  logic [DW-1:0] ctl_wdata = '0, ctl_rdata;
  logic xfer_req = 1'b0, xfer_dir = 1'b0;
  logic [LW-1:0] xfer_len = '0, xfer_len_out;
  logic xfer_ack, xfer_grant;
  logic core_done = 1'b0, core_irq = 1'b0;
  logic core_en, core_cancel, irq;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.DATA_W(DW), .LEN_W(LW), .MODE_BIT(12)) uut (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_len(xfer_len),
    .xfer_ack(xfer_ack), .xfer_grant(xfer_grant), .xfer_len_out(xfer_len_out),
    .core_done(core_done), .core_irq(core_irq),
    .core_en(core_en), .core_cancel(core_cancel), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference model
  logic [DW-1:0] m [8];
  logic [DW-1:0] m_ctl;
  logic m_en;
  logic m_cancel;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] clamp_len(logic [LW-1:0] len, logic [DW-1:0] cnt);
    return (cnt < DW'(len)) ? cnt : DW'(len);
  endfunction

  function automatic logic [DW-1:0] stat_view(logic [DW-1:0] st, logic ci);
    return st | (ci ? 32'h10 : 32'h0);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_outs(string tag, logic exp_ack);
    chk({tag, " core_en"}, DW'(core_en), DW'(m_en));
    chk({tag, " irq R12"}, DW'(irq), DW'(m[7][3] & m[0][6]));
    chk({tag, " cancel R5"}, DW'(core_cancel), DW'(m_cancel));
    chk({tag, " ack"}, DW'(xfer_ack), DW'(exp_ack));
  endtask

  task automatic do_write(int idx, logic [DW-1:0] d, string tag);
    reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
    m_cancel = 1'b0;
    if (idx == 0) begin
      m[0] = d;
      case (d[1:0])
        2'd0: m_en = 1'b0;
        2'd2: begin m_cancel = 1'b1; m[7] = m[7] | 32'h4; end
        2'd3: begin m[4] = m[1]; m[5] = m[2]; m[6] = m[3]; m[7] = '0; m_en = 1'b1; end
        default: ;
      endcase
    end else if (idx == 7) begin
      if (!m_ctl[12]) m[7] = m[7] & ~(d & 32'hE);
    end else begin
      m[idx] = d;
    end
    tick();
    reg_wr = 1'b0;
    check_outs(tag, 1'b0);
  endtask

  task automatic do_read(int idx, string tag);
    logic [DW-1:0] exp;
    reg_rd = 1'b1; reg_idx = 3'(idx);
    exp = (idx == 7) ? stat_view(m[7], core_irq) : m[idx];
    if (idx == 7 && m_ctl[12]) m[7] = m[7] & ~32'hE;
    m_cancel = 1'b0;
    tick();
    reg_rd = 1'b0;
    chk({tag, " rdata"}, reg_rdata, exp);
    check_outs(tag, 1'b0);
  endtask

  task automatic do_ctl(logic [DW-1:0] d, string tag);
    ctl_wr = 1'b1; ctl_wdata = d; m_ctl = d; m_cancel = 1'b0;
    tick();
    ctl_wr = 1'b0;
    chk({tag, " ctl"}, ctl_rdata, m_ctl);
    check_outs(tag, 1'b0);
  endtask

  task automatic do_xfer(logic dir, logic [LW-1:0] len, string tag);
    logic [DW-1:0] take;
    logic ok;
    xfer_req = 1'b1; xfer_dir = dir; xfer_len = len; m_cancel = 1'b0;
    ok = (dir == m[0][7]);
    take = ok ? clamp_len(len, m[4]) : '0;
    if (ok) begin
      m[4] = m[4] - take;
      m[5] = m[5] + take;
      if (m[4] == '0) m[7] = m[7] | 32'h20;
    end else begin
      m[7] = m[7] | 32'h2;
    end
    tick();
    xfer_req = 1'b0;
    chk({tag, " grant"}, DW'(xfer_grant), DW'(ok));
    chk({tag, " len"}, DW'(xfer_len_out), take);
    check_outs(tag, 1'b1);
  endtask

  task automatic do_done(string tag);
    core_done = 1'b1; m_cancel = 1'b0;
    m[4] = '0; m[7] = m[7] | 32'h8;
    tick();
    core_done = 1'b0;
    check_outs(tag, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 8; i++) m[i] = '0;
    m[5] = 32'hFFFF_FFFF; m[6] = 32'hFFFF_FFFD;
    m_ctl = '0; m_en = 1'b0; m_cancel = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset values
    check_outs("R1", 1'b0);
    chk("R1 ctl", ctl_rdata, 32'h0);
    for (int i = 0; i < 8; i++) do_read(i, "R1");

    // R2: index map and readback
    for (int i = 1; i < 7; i++) do_write(i, 32'h1000_0000 * i + 32'h55, "R2");
    for (int i = 1; i < 7; i++) do_read(i, "R2");

    // R3: start reload
    do_write(1, 32'd10, "R3");
    do_write(2, 32'h0000_8000, "R3");
    do_write(3, 32'h0000_4000, "R3");
    do_write(0, 32'h0000_00C3, "R3");
    do_read(4, "R3 wcnt");
    chk("R3 wcnt const", reg_rdata, 32'd10);
    do_read(5, "R3 wadr");
    do_read(6, "R3 wdsc");
    do_read(7, "R3 stat");

    // R6: clamp and counters
    do_xfer(1'b1, 16'd4, "R6");
    do_xfer(1'b1, 16'd20, "R6 clamp");
    chk("R6 clamp const", DW'(xfer_len_out), 32'd6);
    do_read(4, "R6 wcnt");
    do_read(5, "R6 wadr");
    chk("R6 wadr const", reg_rdata, 32'h0000_800A);

    // R7: wrong direction
    do_write(1, 32'd50, "R7");
    do_write(0, 32'h0000_0043, "R7");
    do_xfer(1'b1, 16'd8, "R7 reject");
    do_read(4, "R7 wcnt");
    do_read(5, "R7 wadr");

    // R9: write-one-to-clear mode
    do_read(7, "R9 err set");
    do_write(7, 32'h0000_0002, "R9 clear");
    do_read(7, "R9 after");
    // R5: abort
    do_write(0, 32'h0000_0042, "R5 abort");
    do_read(7, "R5 stat");

    // R8 / R12: completion with done interrupt enabled
    do_done("R8");
    do_read(4, "R8 wcnt");
    chk("R12 irq const", DW'(irq), 32'd1);

    // R10: clear-on-read mode
    do_ctl(32'h0000_1000, "R10");
    do_write(7, 32'h0000_000E, "R10 write ignored");
    do_read(7, "R10 first");
    do_read(7, "R10 second");

    // R11: core interrupt seen in status
    core_irq = 1'b1;
    do_read(7, "R11");
    core_irq = 1'b0;
    do_read(7, "R11 off");

    // R4: blast keeps enable, idle drops it
    do_write(0, 32'h0000_0003, "R4 start");
    do_write(0, 32'h0000_0001, "R4 blast");
    do_read(4, "R4 blast wcnt");
    do_write(0, 32'h0000_0000, "R4 idle");

    // random mix
    for (int k = 0; k < 1500; k++) begin
      int op;
      op = int'($urandom % 9);
      case (op)
        0: do_write(1 + int'($urandom % 6),
                    ($urandom % 2) ? ($urandom % 100) : $urandom, "R2 rnd");
        1: do_write(0, $urandom & 32'h0000_00F7, "R3 rnd cmd");
        2: do_read(int'($urandom % 8), "R2 rnd read");
        3, 4: do_xfer(1'($urandom % 2), 16'($urandom % 64), "R6 rnd xfer");
        5: do_done("R8 rnd");
        6: do_write(7, $urandom & 32'h3F, "R9 rnd stat");
        7: do_ctl(($urandom % 2) ? 32'h1000 : 32'h0, "R10 rnd ctl");
        default: begin
          core_irq = ~core_irq;
          m_cancel = 1'b0;
          tick();
          check_outs("R11 rnd", 1'b0);
        end
      endcase
    end

    summary();
    $finish;
  end

endmodule